// File: doc/BRIEF.md
# Processor Status Trace and Breakpoint Controller

This block drives the trace pins that an external debug probe watches, and it turns a manual breakpoint pin into either a halt request or a debug interrupt for the core. The core supplies a 4-bit status code and a 4-bit captured data nibble every cycle. The block puts both on the trace buses on the falling edge of the processor clock. It also produces a trace clock, which is a gated copy of the processor clock, so the rising edge of the trace clock falls in the middle of each valid output period.

The trace clock stays low after reset. It starts only once the trace status bus has carried one of the codes 0xC, 0xD or 0xF. The quiet control bit freezes the trace buses and the trace clock. It does not stop the breakpoint logic. The interrupt-mode control bit makes a breakpoint raise a one-cycle debug interrupt pulse instead of a halt request.

In halt mode, a request is held until the core reports that its current instruction has completed. The block is then halted and shows 0xF on the trace status bus until the core pulses resume.

The trace outputs are a free-running stream with no handshake. The probe samples them on the trace clock, and no back-pressure is possible. The control inputs and request outputs are plain level or pulse pins.

Top module: `trc_status_ctrl`

## Requirements
- R1: After reset `trc_clk` stays low until a value loaded onto `trc_status` is 0xC, 0xD or 0xF. From that falling edge on, `trc_clk` is high in every high phase of `clk` while quiet is clear, even if later codes are other values.
- R2: Whenever quiet is clear, on every falling edge of `clk` `trc_status` takes the effective status and `trc_data` takes `core_data`. The effective status is `core_status`, or 0xF while halted.
- R3: `trc_all` is 1 exactly when all four bits of `trc_status` are 1.
- R4: While `ctl_quiet` is 1, `trc_status`, `trc_data` and `trc_all` hold their values and `trc_clk` stays low. Breakpoint detection and requests still work.
- R5: After `ctl_quiet` returns to 0, the next falling edge updates the trace buses again and `trc_clk` resumes if it had started.
- R6: With `ctl_brk_irq` = 0, a rising edge on `brk_pin` (after a two-flop synchronizer) sets `halt_req`. `halt_req` stays 1 until a cycle with `insn_done` = 1, which clears it and enters the halted state.
- R7: While halted, `trc_status` shows 0xF.
- R8: A `resume` pulse while halted leaves the halted state, and `trc_status` again follows `core_status`.
- R9: With `ctl_brk_irq` = 1, each rising edge on `brk_pin` gives exactly one one-cycle pulse on `dbg_irq` and no halt request.
- R10: Holding `brk_pin` high gives only one request, however long it is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_status | input | 4 | Status code from the core |
| core_data | input | DATA_W | Captured data nibble from the core |
| brk_pin | input | 1 | Asynchronous manual breakpoint request |
| ctl_quiet | input | 1 | Freezes the trace outputs when 1 |
| ctl_brk_irq | input | 1 | Breakpoint raises a debug interrupt instead of a halt when 1 |
| insn_done | input | 1 | Core finished its current instruction |
| resume | input | 1 | Core leaves the halted state |
| trc_clk | output | 1 | Gated trace clock |
| trc_status | output | 4 | Trace status bus |
| trc_data | output | DATA_W | Trace data bus |
| trc_all | output | 1 | AND of the trace status bits |
| halt_req | output | 1 | Pending halt request to the core |
| dbg_irq | output | 1 | One-cycle debug interrupt request |
| halted | output | 1 | Core is held halted by a breakpoint |

## Verification
Most internal faults show on the trace pins within one cycle:
- A corrupted halted or pending flag shows on `trc_status`, as a missing or stuck 0xF, or on `halt_req` at the next falling edge.
- A bad edge detector shows as repeated or missing `dbg_irq` pulses within three cycles of a change on `brk_pin`.
- A wrong start latch or gate shows as `trc_clk` running before a start code, or staying idle after one, in the very next high phase.

The bench sweeps every status and data value against these expectations.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int ST_W = 4;
  localparam logic [ST_W-1:0] CODE_HALT = 4'hF;
  localparam logic [ST_W-1:0] CODE_S0   = 4'hC;
  localparam logic [ST_W-1:0] CODE_S1   = 4'hD;

  function automatic logic is_start(input logic [ST_W-1:0] c);
    return (c == CODE_S0) || (c == CODE_S1) || (c == CODE_HALT);
  endfunction
endpackage

// File: rtl/trc_brk_sync.sv
module trc_brk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= pin;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], pin};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[STAGES-1];

  assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/trc_brk_ctrl.sv
module trc_brk_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  input  logic irq_mode,
  input  logic insn_done,
  input  logic resume,
  output logic halt_pend,
  output logic halted,
  output logic dbg_irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_pend <= 1'b0;
      halted    <= 1'b0;
      dbg_irq   <= 1'b0;
    end else begin
      dbg_irq <= rise & irq_mode;
      if (halt_pend && insn_done) begin
        halt_pend <= 1'b0;
        halted    <= 1'b1;
      end else if (rise && !irq_mode && !halted) begin
        halt_pend <= 1'b1;
      end
      if (halted && resume) halted <= 1'b0;
    end
  end
endmodule

// File: rtl/trc_out.sv
module trc_out
  import trc_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ST_W-1:0]   eff_status,
  input  logic [DATA_W-1:0] data_in,
  input  logic              quiet,
  output logic [ST_W-1:0]   status_q,
  output logic [DATA_W-1:0] data_q,
  output logic              all_q,
  output logic              gate_q
);
  logic started_q;
  logic started_nx;

  assign started_nx = started_q | is_start(eff_status);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q  <= '0;
      data_q    <= '0;
      all_q     <= 1'b0;
      started_q <= 1'b0;
      gate_q    <= 1'b0;
    end else if (quiet) begin
      gate_q <= 1'b0;
    end else begin
      status_q  <= eff_status;
      data_q    <= data_in;
      all_q     <= &eff_status;
      started_q <= started_nx;
      gate_q    <= started_nx;
    end
  end
endmodule

// File: rtl/trc_status_ctrl.sv
module trc_status_ctrl
  import trc_pkg::*;
#(
  parameter int DATA_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        core_status,
  input  logic [DATA_W-1:0] core_data,
  input  logic              brk_pin,
  input  logic              ctl_quiet,
  input  logic              ctl_brk_irq,
  input  logic              insn_done,
  input  logic              resume,
  output logic              trc_clk,
  output logic [3:0]        trc_status,
  output logic [DATA_W-1:0] trc_data,
  output logic              trc_all,
  output logic              halt_req,
  output logic              dbg_irq,
  output logic              halted
);
  logic            rise;
  logic            gate_q;
  logic [ST_W-1:0] eff_status;

  trc_brk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(brk_pin), .rise(rise)
  );

  trc_brk_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .rise(rise), .irq_mode(ctl_brk_irq),
    .insn_done(insn_done), .resume(resume),
    .halt_pend(halt_req), .halted(halted), .dbg_irq(dbg_irq)
  );

  assign eff_status = halted ? CODE_HALT : core_status;

  trc_out #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .eff_status(eff_status), .data_in(core_data),
    .quiet(ctl_quiet), .status_q(trc_status), .data_q(trc_data),
    .all_q(trc_all), .gate_q(gate_q)
  );

  assign trc_clk = clk & gate_q;
endmodule

// File: rtl/trc_status_chk.sv
module trc_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_quiet,
  input logic       ctl_brk_irq,
  input logic       insn_done,
  input logic [3:0] trc_status,
  input logic       trc_all,
  input logic       halt_req,
  input logic       dbg_irq,
  input logic       halted
);
  p_all_and_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trc_all == (&trc_status));

  p_quiet_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_quiet |-> $stable(trc_status));

  p_halt_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && $past(halted) && !ctl_quiet) |-> trc_status == 4'hF);

  p_halt_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> $past(halt_req && insn_done));

  p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_irq |=> !dbg_irq);

  p_irq_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_irq |-> $past(ctl_brk_irq));
endmodule

bind trc_status_ctrl trc_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_quiet(ctl_quiet), .ctl_brk_irq(ctl_brk_irq),
  .insn_done(insn_done), .trc_status(trc_status), .trc_all(trc_all),
  .halt_req(halt_req), .dbg_irq(dbg_irq), .halted(halted)
);

// File: tb/trc_status_ctrl_bench.sv
module trc_status_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] core_status = '0;
  logic [3:0] core_data = '0;
  logic       brk_pin = 1'b0, ctl_quiet = 1'b0, ctl_brk_irq = 1'b0;
  logic       insn_done = 1'b0, resume = 1'b0;
  logic       trc_clk, trc_all, halt_req, dbg_irq, halted;
  logic [3:0] trc_status, trc_data;
  int checks = 0, errors = 0, irq_count = 0;
  bit done = 0;

  always #4 clk = ~clk;

  trc_status_ctrl u_trc_status_ctrl (
    .clk(clk), .rst_n(rst_n), .core_status(core_status), .core_data(core_data),
    .brk_pin(brk_pin), .ctl_quiet(ctl_quiet), .ctl_brk_irq(ctl_brk_irq),
    .insn_done(insn_done), .resume(resume), .trc_clk(trc_clk),
    .trc_status(trc_status), .trc_data(trc_data), .trc_all(trc_all),
    .halt_req(halt_req), .dbg_irq(dbg_irq), .halted(halted)
  );

  always @(negedge clk) if (dbg_irq) irq_count++;

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    core_status = 0; core_data = 0; brk_pin = 0; ctl_quiet = 0;
    ctl_brk_irq = 0; insn_done = 0; resume = 0;
    rst_n = 0;
    tick(2);
    rst_n = 1;
    tick(1);
  endtask

  initial begin
    do_reset();
    chk("R1 reset trc_clk", trc_clk, 0);
    chk("R2 reset status", trc_status, 0);
    chk("R3 reset all", trc_all, 0);
    chk("R6 reset halt_req", halt_req, 0);
    chk("R9 reset dbg_irq", dbg_irq, 0);

    // R1 R2 R3: sweep every code as first value after reset
    for (int v = 0; v < 16; v++) begin
      do_reset();
      core_status = 4'(v);
      tick(1);
      chk("R1 start on code", trc_clk, (v == 12 || v == 13 || v == 15) ? 1 : 0);
      chk("R2 status follows", trc_status, v);
      chk("R3 all flag", trc_all, (v == 15) ? 1 : 0);
      core_status = 4'h0;
      tick(1);
      chk("R1 clock latched", trc_clk, (v == 12 || v == 13 || v == 15) ? 1 : 0);
    end

    // R2: data sweep
    for (int d = 0; d < 16; d++) begin
      core_data = 4'(d);
      tick(1);
      chk("R2 data follows", trc_data, d);
    end

    // R4 R5: quiet freezes trace outputs, triggers keep working
    core_status = 4'h3; core_data = 4'h5;
    tick(1);
    ctl_quiet = 1;
    core_status = 4'h9; core_data = 4'hA;
    tick(1);
    chk("R4 quiet status hold", trc_status, 3);
    chk("R4 quiet data hold", trc_data, 5);
    chk("R4 quiet clk low", trc_clk, 0);
    ctl_brk_irq = 1; irq_count = 0;
    brk_pin = 1;
    tick(5);
    chk("R4 trigger under quiet", irq_count, 1);
    chk("R4 quiet status still held", trc_status, 3);
    brk_pin = 0;
    tick(3);
    ctl_quiet = 0;
    tick(1);
    chk("R5 status resumes", trc_status, 9);
    chk("R5 data resumes", trc_data, 10);
    chk("R5 clk resumes", trc_clk, 1);

    // R9 R10: interrupt mode, long hold gives one pulse
    irq_count = 0;
    brk_pin = 1;
    tick(10);
    chk("R10 one irq for long hold", irq_count, 1);
    chk("R9 no halt in irq mode", halt_req, 0);
    brk_pin = 0;
    tick(3);
    brk_pin = 1;
    tick(4);
    brk_pin = 0;
    tick(3);
    chk("R9 second irq", irq_count, 2);

    // R6 R7 R8: halt flow
    ctl_brk_irq = 0; irq_count = 0;
    core_status = 4'h3;
    brk_pin = 1;
    tick(4);
    chk("R6 halt_req set", halt_req, 1);
    chk("R6 status before halt", trc_status, 3);
    tick(3);
    chk("R6 halt_req held", halt_req, 1);
    insn_done = 1;
    tick(1);
    insn_done = 0;
    chk("R6 halt_req cleared", halt_req, 0);
    chk("R6 halted", halted, 1);
    tick(1);
    chk("R7 shows F", trc_status, 15);
    chk("R7 all set while halted", trc_all, 1);
    resume = 1;
    tick(1);
    resume = 0;
    chk("R8 halted cleared", halted, 0);
    tick(1);
    chk("R8 status follows core", trc_status, 3);
    tick(4);
    chk("R10 no new halt while held", halt_req, 0);
    chk("R9 no irq in halt mode", irq_count, 0);
    brk_pin = 0;
    tick(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule